// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock for an I2C bus master from a much faster core clock. Software programs a divider, and the block drives SCL low for one half of the divided period and releases it for the other half. It also emits two single-cycle strobes. The drive strobe tells the data path when to change SDA, a set number of core clocks after SCL falls. The sample strobe tells it when to capture SDA, a set number of core clocks after SCL is seen high.

The high half of each period counts only cycles in which SCL is actually sensed high. A slave that holds the line low therefore stretches the clock. While that lasts, a watchdog counts whole SCL periods. When the stretch reaches a programmed number of periods, the watchdog sets a sticky flag that software clears by writing a one to it.

Software reaches five word-wide registers through a write port and a combinational read port:

| Address | Register |
|---------|----------|
| 0 | divider |
| 1 | drive-strobe delay |
| 2 | sample-strobe delay |
| 3 | stretch limit |
| 4 | status, with the timeout flag in bit 0 |

Each register keeps only its low field. Unused upper bits read back as zero.

Top module: `sclk_timing_gen`

## Requirements
- R1: The divider register (address 0) keeps only bits 15:0 of a write. Bits 31:16 and every unused bit of the other registers read back as zero. The status register (address 4) keeps only bit 0, which is the timeout flag.
- R2: The effective divider is the programmed value with bit 0 cleared. Any non-zero value that clears to 0 (that is, 1) is used as 2.
- R3: A programmed divider of 0 gives an effective divider of 32768 core clocks.
- R4: Once enabled, the block pulls SCL low from the first cycle after `enable` is seen. Each low phase and each unstretched high phase lasts exactly half the effective divider, in core clocks.
- R5: `sda_drive_stb` is high for one cycle, in the cycle whose index within the low phase equals the drive delay. Index 0 is the first cycle with SCL pulled low. This holds for delays below half the divider.
- R6: `sda_sample_stb` is high for one cycle, in the high-phase cycle whose count of sensed-high cycles before it equals the sample delay. The first sensed-high cycle has count 0.
- R7: While SCL is released but sensed low, the block keeps SCL released and its high-phase count does not advance. After the line rises, the high phase still lasts a full half divider.
- R8: With a non-zero limit L and effective divider E, the timeout flag rises only after a stretch of at least L*E+1 core-clock edges. A stretch of exactly L*E edges leaves it clear.
- R9: A stretch limit of 0 disables the timeout, however long the stretch lasts.
- R10: The timeout flag stays set until a write to the status register with bit 0 at 1 clears it. A write there with bit 0 at 0 has no effect.
- R11: A divider written while the block is running does not change the SCL period in progress. It applies from the next period.
- R12: While `enable` is low, SCL is released and neither strobe fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the SCL generator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_stb | output | 1 | Strobe at which SDA may change |
| sda_sample_stb | output | 1 | Strobe at which SDA is captured |
| stretch_timeout | output | 1 | Sticky clock-stretch timeout flag |

## Verification
The bench builds the block with its default 16-bit divider, delay and limit fields. This is what makes the zero-divider case of 32768 clocks reachable. The bench sweeps every divider from 1 to 10, and for each one every pair of drive and sample delays below half the divider. Those small dividers keep each period short enough for a complete sweep. A limit of 2 with a divider of 8 places the timeout edge at the 17th stretched cycle, which lets the bench probe both sides of it.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic [2:0] {
    A_DIV  = 3'd0,
    A_FDLY = 3'd1,
    A_RDLY = 3'd2,
    A_TOUT = 3'd3,
    A_STAT = 3'd4
  } reg_addr_e;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Effective SCL period in core clocks for a raw divider field of width w.
  function automatic logic [31:0] eff_divider(input logic [31:0] raw, input int unsigned w);
    logic [31:0] e;
    e = raw & ~32'd1;
    if (raw == 32'd0)
      e = 32'd1 << (w - 1);
    else if (e < 32'd2)
      e = 32'd2;
    return e;
  endfunction

endpackage

// File: rtl/sclk_regs.sv
module sclk_regs
  import sclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic [DIV_W-1:0] div_q,
  output logic [DLY_W-1:0] fdly_q,
  output logic [DLY_W-1:0] rdly_q,
  output logic [TO_W-1:0]  tout_q,
  input  logic             to_set,
  output logic             to_flag
);

  logic wr_div, wr_fdly, wr_rdly, wr_tout, clr_flag;

  assign wr_div   = wr_en && (wr_addr == A_DIV);
  assign wr_fdly  = wr_en && (wr_addr == A_FDLY);
  assign wr_rdly  = wr_en && (wr_addr == A_RDLY);
  assign wr_tout  = wr_en && (wr_addr == A_TOUT);
  assign clr_flag = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      fdly_q  <= '0;
      rdly_q  <= '0;
      tout_q  <= '0;
      to_flag <= 1'b0;
    end else begin
      if (wr_div)  div_q  <= wr_data[DIV_W-1:0];
      if (wr_fdly) fdly_q <= wr_data[DLY_W-1:0];
      if (wr_rdly) rdly_q <= wr_data[DLY_W-1:0];
      if (wr_tout) tout_q <= wr_data[TO_W-1:0];
      if (to_set)
        to_flag <= 1'b1;
      else if (clr_flag)
        to_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_data = 32'd0;
    case (rd_addr)
      A_DIV:   rd_data = 32'(div_q);
      A_FDLY:  rd_data = 32'(fdly_q);
      A_RDLY:  rd_data = 32'(rdly_q);
      A_TOUT:  rd_data = 32'(tout_q);
      A_STAT:  rd_data = {31'd0, to_flag};
      default: rd_data = 32'd0;
    endcase
  end

  // R10: the flag only falls through an explicit clear write
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !clr_flag) |=> to_flag);

  // R9: with the limit at zero a clear flag never rises
  a_r9_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_q == '0 && !wr_tout && !to_flag) |=> !to_flag);

  // R1: the divider field never holds more than DIV_W bits
  a_r1_div_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_DIV) |-> (rd_data[31:DIV_W] == '0));

endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
  import sclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_raw,
  input  logic [DLY_W-1:0] fdly,
  input  logic [DLY_W-1:0] rdly,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             stretching,
  output logic [DIV_W-1:0] cur_eff
);

  phase_e           phase;
  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cur_half;
  logic [DIV_W-1:0] new_half;
  logic [31:0]      eff_w;
  logic             low_done, high_done, start_evt;

  assign eff_w     = eff_divider(32'(div_raw), DIV_W);
  assign new_half  = DIV_W'(eff_w >> 1);
  assign low_done  = (cnt == cur_half - 1'b1);
  assign high_done = scl_in && (cnt == cur_half - 1'b1);
  assign start_evt = enable && (!active || (phase == PH_HIGH && high_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase    <= PH_LOW;
      cnt      <= '0;
      cur_half <= DIV_W'(1);
    end else if (!enable) begin
      active <= 1'b0;
      phase  <= PH_LOW;
      cnt    <= '0;
    end else if (!active) begin
      active   <= 1'b1;
      phase    <= PH_LOW;
      cnt      <= '0;
      cur_half <= new_half;
    end else begin
      case (phase)
        PH_LOW: begin
          if (low_done) begin
            phase <= PH_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (scl_in) begin
            if (high_done) begin
              phase    <= PH_LOW;
              cnt      <= '0;
              cur_half <= new_half;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign scl_pull_low = active && (phase == PH_LOW);
  assign stretching   = active && (phase == PH_HIGH) && !scl_in;
  assign fall_stb     = active && (phase == PH_LOW) && (32'(fdly) == 32'(cnt));
  assign rise_stb     = active && (phase == PH_HIGH) && scl_in && (32'(rdly) == 32'(cnt));
  assign cur_eff      = {cur_half[DIV_W-2:0], 1'b0};

  // R4: the low phase count stays inside the latched half period
  a_r4_low_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase == PH_LOW) |-> (cnt < cur_half));

  // R7: a stretched high phase does not advance
  a_r7_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stretching |=> (!active || $stable(cnt)));

  // R11: the latched half period moves only at a period start
  a_r11_latch_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_half) |-> $past(start_evt));

  // R12: disabling releases the line and silences the strobes
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !fall_stb && (!rise_stb || enable)));

endmodule

// File: rtl/sclk_stretch_wd.sv
module sclk_stretch_wd #(
  parameter int DIV_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stretching,
  input  logic [DIV_W-1:0] cur_eff,
  input  logic [TO_W-1:0]  limit,
  output logic             to_set
);

  logic [DIV_W-1:0] sub_cnt;
  logic [TO_W-1:0]  per_cnt;
  logic             per_wrap;

  assign per_wrap = (sub_cnt == cur_eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_cnt <= '0;
      per_cnt <= '0;
    end else if (!stretching) begin
      sub_cnt <= '0;
      per_cnt <= '0;
    end else if (per_wrap) begin
      sub_cnt <= '0;
      if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
    end else begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

  assign to_set = stretching && (limit != '0) && (per_cnt >= limit);

  // R8: the period count never falls during one continuous stretch
  a_r8_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (stretching && $past(stretching)) |-> (per_cnt >= $past(per_cnt)));

endmodule

// File: rtl/sclk_timing_gen.sv
module sclk_timing_gen
  import sclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16,
  parameter int TO_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        scl_in,
  output logic        scl_pull_low,
  output logic        sda_drive_stb,
  output logic        sda_sample_stb,
  output logic        stretch_timeout
);

  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] fdly_q, rdly_q;
  logic [TO_W-1:0]  tout_q;
  logic [DIV_W-1:0] cur_eff;
  logic             stretching, to_set;

  sclk_regs #(.DIV_W(DIV_W), .DLY_W(DLY_W), .TO_W(TO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .div_q(div_q), .fdly_q(fdly_q),
    .rdly_q(rdly_q), .tout_q(tout_q), .to_set(to_set), .to_flag(stretch_timeout)
  );

  sclk_phase #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_raw(div_q), .fdly(fdly_q),
    .rdly(rdly_q), .scl_in(scl_in), .scl_pull_low(scl_pull_low),
    .fall_stb(sda_drive_stb), .rise_stb(sda_sample_stb),
    .stretching(stretching), .cur_eff(cur_eff)
  );

  sclk_stretch_wd #(.DIV_W(DIV_W), .TO_W(TO_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .stretching(stretching), .cur_eff(cur_eff),
    .limit(tout_q), .to_set(to_set)
  );

  // R2: the running period is always even and at least two clocks
  a_r2_even_period: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_low) |-> (cur_eff[0] == 1'b0 && cur_eff != '0));

  // R7: a stretch never coincides with the line being pulled low
  a_r7_no_pull_in_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    stretching |-> !scl_pull_low);

endmodule

// File: tb/sclk_timing_gen_test.sv
module sclk_timing_gen_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_addr = 3'd0;
  logic [31:0] rd_data;
  logic        slave_hold = 1'b0;
  logic        scl_in;
  logic        scl_pull_low, sda_drive_stb, sda_sample_stb, stretch_timeout;

  int checks = 0;
  int errors = 0;

  assign scl_in = !scl_pull_low && !slave_hold;

  always #(CLK_P/2) clk = ~clk;

  sclk_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .scl_in(scl_in),
    .scl_pull_low(scl_pull_low), .sda_drive_stb(sda_drive_stb),
    .sda_sample_stb(sda_sample_stb), .stretch_timeout(stretch_timeout)
  );

  function automatic int exp_eff(input int d);
    if (d == 0) return 32768;
    if ((d / 2) * 2 < 2) return 2;
    return (d / 2) * 2;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic measure(output int lo, output int hi, output int fp, output int rp,
                         input bit do_w, input logic [31:0] wv);
    while (scl_pull_low) @(negedge clk);
    while (!scl_pull_low) @(negedge clk);
    lo = 0; hi = 0; fp = -1; rp = -1;
    while (scl_pull_low) begin
      if (sda_drive_stb) fp = lo;
      if (do_w && lo == 0) begin
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = wv;
      end else begin
        wr_en = 1'b0;
      end
      lo++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    while (!scl_pull_low) begin
      if (sda_sample_stb) rp = hi;
      hi++;
      @(negedge clk);
    end
  endtask

  // Holds SCL low for s stretched edges from the start of a high phase.
  task automatic stretch(input int s, output int after_hi, output int rpos, output bit pulled);
    while (scl_pull_low) @(negedge clk);
    while (!scl_pull_low) @(negedge clk);
    slave_hold = 1'b1;
    while (scl_pull_low) @(negedge clk);
    pulled = 1'b0;
    for (int k = 1; k <= s; k++) begin
      if (scl_pull_low) pulled = 1'b1;
      @(negedge clk);
    end
    if (scl_pull_low) pulled = 1'b1;
    slave_hold = 1'b0;
    #1;
    after_hi = 0; rpos = -1;
    while (!scl_pull_low) begin
      if (sda_sample_stb) rpos = after_hi;
      after_hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lo, hi, fp, rp, ah;
    bit pulled;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(!scl_pull_low, "R12 reset pull", scl_pull_low, 0);
    chk(!stretch_timeout, "R10 reset flag", stretch_timeout, 0);
    rd(3'd0, v);
    chk(v == 0, "R1 reset div", v, 0);

    // R1: register field widths
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v);
    chk(v == 32'h0000_FFFF, "R1 div upper", v, 32'h0000_FFFF);
    wr(3'd1, 32'hABCD_0003);
    rd(3'd1, v);
    chk(v == 32'h0000_0003, "R1 fdly upper", v, 3);
    wr(3'd4, 32'hFFFF_FFFE);
    rd(3'd4, v);
    chk(v == 32'd0, "R1 status reserved", v, 0);
    wr(3'd0, 32'h0001_0006);
    rd(3'd0, v);
    chk(v == 32'd6, "R1 div truncation", v, 6);

    // R4: pull-low begins one cycle after enable is seen
    wr(3'd1, 0); wr(3'd2, 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(scl_pull_low, "R4 first low", scl_pull_low, 1);
    chk(sda_drive_stb, "R5 strobe at zero delay", sda_drive_stb, 1);
    measure(lo, hi, fp, rp, 1'b0, 0);
    chk(lo == 3 && hi == 3, "R4 div 0x10006", lo * 100 + hi, 303);
    enable = 1'b0;

    // R2 R4 R5 R6: exhaustive over small dividers and in-range delays
    for (int d = 1; d <= 10; d++) begin
      for (int f = 0; f < exp_eff(d) / 2; f++) begin
        for (int r = 0; r < exp_eff(d) / 2; r++) begin
          enable = 1'b0;
          wr(3'd0, d); wr(3'd1, f); wr(3'd2, r);
          enable = 1'b1;
          measure(lo, hi, fp, rp, 1'b0, 0);
          chk(lo == exp_eff(d) / 2, "R2 R4 low time", lo, exp_eff(d) / 2);
          chk(hi == exp_eff(d) / 2, "R2 R4 high time", hi, exp_eff(d) / 2);
          chk(fp == f, "R5 drive strobe", fp, f);
          chk(rp == r, "R6 sample strobe", rp, r);
        end
      end
    end

    // R11: a divider change applies from the next period
    enable = 1'b0;
    wr(3'd0, 8); wr(3'd1, 0); wr(3'd2, 0);
    enable = 1'b1;
    measure(lo, hi, fp, rp, 1'b1, 32'd4);
    chk(lo == 4 && hi == 4, "R11 current period kept", lo * 100 + hi, 404);
    measure(lo, hi, fp, rp, 1'b0, 0);
    chk(lo == 2 && hi == 2, "R11 next period new", lo * 100 + hi, 202);

    // R12: disabled means released and quiet
    enable = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0 || k == 11)
        chk(!scl_pull_low && !sda_drive_stb && !sda_sample_stb, "R12 idle",
            {scl_pull_low, sda_drive_stb, sda_sample_stb}, 0);
    end

    // R7 R8 R10: stretch timing against limit 2, divider 8
    wr(3'd0, 8); wr(3'd1, 0); wr(3'd2, 1); wr(3'd3, 2);
    wr(3'd4, 1);
    enable = 1'b1;
    stretch(16, ah, rp, pulled);
    chk(!pulled, "R7 released during stretch", pulled, 0);
    chk(ah == 4, "R7 high after release", ah, 4);
    chk(rp == 1, "R6 R7 sample after release", rp, 1);
    @(negedge clk);
    chk(!stretch_timeout, "R8 no flag at L*E", stretch_timeout, 0);
    stretch(17, ah, rp, pulled);
    @(negedge clk);
    chk(stretch_timeout, "R8 flag at L*E+1", stretch_timeout, 1);
    wr(3'd4, 32'hFFFF_FFFE);
    chk(stretch_timeout, "R10 zero write keeps flag", stretch_timeout, 1);
    rd(3'd4, v);
    chk(v == 32'd1, "R10 R1 status read", v, 1);
    wr(3'd4, 32'd1);
    chk(!stretch_timeout, "R10 clear", stretch_timeout, 0);

    // R9: limit zero never times out
    wr(3'd3, 0);
    stretch(60, ah, rp, pulled);
    @(negedge clk);
    chk(!stretch_timeout, "R9 disabled timeout", stretch_timeout, 0);

    // R3: zero divider gives 32768 clocks
    enable = 1'b0;
    wr(3'd0, 0);
    enable = 1'b1;
    measure(lo, hi, fp, rp, 1'b0, 0);
    chk(lo == 16384, "R3 low half", lo, 16384);
    chk(hi == 16384, "R3 high half", hi, 16384);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule